// File: doc/BRIEF.md
# Synthesizer Serial Divider Loader

This block receives divider and option settings for a frequency synthesizer over a three-wire serial link: a shift clock, a data line and a latch strobe. Bits arrive most significant first and collect in a 20-bit shift register. When the strobe rises, the two bits that arrived last act as an address. That address sends the rest of the word to one of three holding registers: the feedback (N) divide value, the option pair (standby request and open-drain switch), or the reference count together with the lock-indicator select.

The three serial wires are asynchronous to the block clock. They pass through a synchronizer, and edges are found in the `clk` domain, so the serial clock must run well below `clk`. The held fields drive the rest of the synthesizer directly. A gated lock indicator is also provided. It is forced low when the select's top bit is clear, and it reads high while standby is requested.

Top module: `synth_ser_loader`

## Requirements
- R1: After reset, `nDiv`, `refDiv`, `optSw` and `standby` are 0 and `ldSel` is 3'b100.
- R2: Each rising edge of `serClk` shifts `serData` into the LSB of a 20-bit word, so the first bit sent ends at bit 19 and the last bit sent ends at bit 0.
- R3: On a rising `serLe`, if word bit 0 is 0 (address 00 or 10), `nDiv` takes word[19:2] and every other output field keeps its value.
- R4: On a rising `serLe` with word[1:0] = 01, `standby` takes word[19] and `optSw` takes word[18`]; word[17:2] have no effect and `nDiv`, `refDiv`, `ldSel` keep their values.
- R5: On a rising `serLe` with word[1:0] = 11, `refDiv` takes word[17:5] and `ldSel` takes word[4:2]; word[19:18] have no effect and `nDiv`, `standby`, `optSw` keep their values.
- R6: Held fields change only on a rising `serLe`; shifting a full word while `serLe` stays low leaves every output unchanged.
- R7: If `serLe` rises after fewer than 20 new bits, the shift register is transferred as it stands: the new bits sit in the low positions and the older bits are moved up by that count.
- R8: `lockOut` is 0 whenever `ldSel[2]` is 0. When `ldSel[2]` is 1, `lockOut` is 1 while `standby` is 1 and otherwise follows `lockRaw`.
- R9: Entering and leaving standby (`standby` 1 then 0) leaves `nDiv`, `refDiv` and `ldSel` at their loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, MSB first |
| serLe | input | 1 | Latch strobe; a rising edge transfers the word |
| lockRaw | input | 1 | Raw lock indication from the phase detector |
| nDiv | output | 18 | Held feedback divide value |
| refDiv | output | 13 | Held reference count |
| ldSel | output | 3 | Held lock-indicator select |
| optSw | output | 1 | Held open-drain switch bit |
| standby | output | 1 | Held standby request |
| lockOut | output | 1 | Gated lock indicator |

## Verification
The hardest case to reach from the pins is a transfer of a partial word. The resulting register contents depend on what earlier words left in the shift register. The bench therefore keeps its own 20-bit model of the serial history. It sends seven bits after a full word, raises the strobe, and predicts the new fields from that model. The ignored-bit cases use option and reference words whose unused positions are full of ones, and then confirm that the other fields did not move.

// File: rtl/synth_ser_pkg.sv
package synth_ser_pkg;
  localparam int WORD_W = 20;
  localparam int CTL_W  = 2;
  localparam int N_W    = 18;
  localparam int R_W    = 13;
  localparam int LDS_W  = 3;
  localparam logic [LDS_W-1:0] LDSEL_RESET = 3'b100;

  typedef struct packed {
    logic shiftEn;
    logic loadN;
    logic loadOpt;
    logic loadRef;
  } serStrobe_t;
endpackage

// File: rtl/synth_ser_ctl.sv
module synth_ser_ctl
  import synth_ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serData,
  input  logic             serLe,
  input  logic [CTL_W-1:0] ctlBits,
  output logic             dataBit,
  output serStrobe_t       strobes
);
  localparam int NUM_IN = 3;
  localparam int TOP = SYNC_STAGES - 1;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncOut;
  logic [NUM_IN-1:0] prevOut;

  assign rawIn = {serLe, serData, serClk};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain      <= '0;
        prevOut[g] <= 1'b0;
      end else begin
        chain      <= {chain[SYNC_STAGES-2:0], rawIn[g]};
        prevOut[g] <= chain[TOP];
      end
    end
    assign syncOut[g] = chain[TOP];
  end

  logic clkRise, leRise;
  assign clkRise = syncOut[0] & ~prevOut[0];
  assign leRise  = syncOut[2] & ~prevOut[2];
  assign dataBit = syncOut[1];

  always_comb begin
    strobes.shiftEn = clkRise;
    strobes.loadN   = leRise & ~ctlBits[0];
    strobes.loadOpt = leRise & (ctlBits == 2'b01);
    strobes.loadRef = leRise & (ctlBits == 2'b11);
  end
endmodule

// File: rtl/synth_ser_dp.sv
module synth_ser_dp
  import synth_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataBit,
  input  serStrobe_t        strobes,
  input  logic              lockRaw,
  output logic [WORD_W-1:0] shiftWord,
  output logic [N_W-1:0]    nDiv,
  output logic [R_W-1:0]    refDiv,
  output logic [LDS_W-1:0]  ldSel,
  output logic              optSw,
  output logic              standby,
  output logic              lockOut
);
  localparam int PAY_LSB = CTL_W;
  localparam int LDS_LSB = CTL_W;
  localparam int R_LSB   = CTL_W + LDS_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftWord <= '0;
    else if (strobes.shiftEn) shiftWord <= {shiftWord[WORD_W-2:0], dataBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nDiv <= '0;
    else if (strobes.loadN) nDiv <= shiftWord[PAY_LSB +: N_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      standby <= 1'b0;
      optSw   <= 1'b0;
    end else if (strobes.loadOpt) begin
      standby <= shiftWord[WORD_W-1];
      optSw   <= shiftWord[WORD_W-2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refDiv <= '0;
      ldSel  <= LDSEL_RESET;
    end else if (strobes.loadRef) begin
      refDiv <= shiftWord[R_LSB +: R_W];
      ldSel  <= shiftWord[LDS_LSB +: LDS_W];
    end
  end

  assign lockOut = ldSel[LDS_W-1] & (standby | lockRaw);
endmodule

// File: rtl/synth_ser_loader.sv
module synth_ser_loader
  import synth_ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLe,
  input  logic              lockRaw,
  output logic [N_W-1:0]    nDiv,
  output logic [R_W-1:0]    refDiv,
  output logic [LDS_W-1:0]  ldSel,
  output logic              optSw,
  output logic              standby,
  output logic              lockOut
);
  serStrobe_t        strobes;
  logic              dataBit;
  logic [WORD_W-1:0] shiftWord;

  synth_ser_ctl #(.SYNC_STAGES(SYNC_STAGES)) i_ctl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLe(serLe),
    .ctlBits(shiftWord[CTL_W-1:0]), .dataBit(dataBit), .strobes(strobes)
  );

  synth_ser_dp i_dp (
    .clk(clk), .rstN(rstN), .dataBit(dataBit), .strobes(strobes), .lockRaw(lockRaw),
    .shiftWord(shiftWord), .nDiv(nDiv), .refDiv(refDiv), .ldSel(ldSel),
    .optSw(optSw), .standby(standby), .lockOut(lockOut)
  );
endmodule

// File: rtl/synth_ser_checker.sv
module synth_ser_checker
  import synth_ser_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              loadN,
  input logic              loadOpt,
  input logic              loadRef,
  input logic [WORD_W-1:0] shiftWord,
  input logic [N_W-1:0]    nDiv,
  input logic [R_W-1:0]    refDiv,
  input logic [LDS_W-1:0]  ldSel,
  input logic              optSw,
  input logic              standby
);
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadN, loadOpt, loadRef}));

  p_n_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadN |=> nDiv == $past(shiftWord[19:2]));

  p_opt_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    loadOpt |=> (standby == $past(shiftWord[19])) && (optSw == $past(shiftWord[18])));

  p_ref_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadRef |=> (refDiv == $past(shiftWord[17:5])) && (ldSel == $past(shiftWord[4:2])));

  p_n_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> $stable(nDiv));

  p_opt_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !loadOpt |=> $stable(standby) && $stable(optSw));

  p_ref_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !loadRef |=> $stable(refDiv) && $stable(ldSel));
endmodule

bind synth_ser_loader synth_ser_checker i_chk (
  .clk(clk), .rstN(rstN),
  .loadN(strobes.loadN), .loadOpt(strobes.loadOpt), .loadRef(strobes.loadRef),
  .shiftWord(shiftWord), .nDiv(nDiv), .refDiv(refDiv), .ldSel(ldSel),
  .optSw(optSw), .standby(standby)
);

// File: tb/test_synth_ser_loader.sv
module test_synth_ser_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLe = 1'b0, lockRaw = 1'b0;
  logic [17:0] nDiv;
  logic [12:0] refDiv;
  logic [2:0]  ldSel;
  logic optSw, standby, lockOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [19:0] model = '0;
  logic [17:0] expN = '0;
  logic [12:0] expR = '0;
  logic [2:0]  expLd = 3'b100;
  logic expSw = 0, expStb = 0;

  always #2.5 clk = ~clk;

  synth_ser_loader i_synth_ser_loader (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLe(serLe),
    .lockRaw(lockRaw), .nDiv(nDiv), .refDiv(refDiv), .ldSel(ldSel),
    .optSw(optSw), .standby(standby), .lockOut(lockOut)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string req);
    chk(req, "nDiv", 20'(nDiv), 20'(expN));
    chk(req, "refDiv", 20'(refDiv), 20'(expR));
    chk(req, "ldSel", 20'(ldSel), 20'(expLd));
    chk(req, "optSw", 20'(optSw), 20'(expSw));
    chk(req, "standby", 20'(standby), 20'(expStb));
  endtask

  task automatic sendBits(input logic [19:0] w, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      serData = w[i];
      waitClk(4);
      serClk = 1'b1;
      model = {model[18:0], w[i]};
      waitClk(4);
      serClk = 1'b0;
    end
    waitClk(6);
  endtask

  task automatic pulseLe();
    serLe = 1'b1;
    if (model[0] == 1'b0) expN = model[19:2];
    else if (model[1] == 1'b0) begin expStb = model[19]; expSw = model[18]; end
    else begin expR = model[17:5]; expLd = model[4:2]; end
    waitClk(8);
    serLe = 1'b0;
    waitClk(6);
  endtask

  task automatic t_reset();
    chkAll("R1");
  endtask

  task automatic t_nload();
    sendBits({18'd10000, 2'b00}, 20); pulseLe();
    chkAll("R2 R3 addr00");
    sendBits({18'h3FFFF, 2'b10}, 20); pulseLe();
    chkAll("R3 addr10");
    sendBits({18'h2B5C3, 2'b00}, 20); pulseLe();
    chkAll("R2 pattern");
  endtask

  task automatic t_opt();
    sendBits({1'b1, 1'b0, 16'hFFFF, 2'b01}, 20); pulseLe();
    chkAll("R4 stb");
    sendBits({1'b0, 1'b1, 16'hFFFF, 2'b01}, 20); pulseLe();
    chkAll("R4 sw");
  endtask

  task automatic t_ref();
    sendBits({2'b11, 13'd5, 3'b101, 2'b11}, 20); pulseLe();
    chkAll("R5 min");
    sendBits({2'b11, 13'h1FFF, 3'b100, 2'b11}, 20); pulseLe();
    chkAll("R5 max");
  endtask

  task automatic t_noLe();
    sendBits({18'h00ABC, 2'b00}, 20);
    chkAll("R6 no strobe");
    pulseLe();
    chkAll("R6 strobe");
  endtask

  task automatic t_partial();
    sendBits({18'h12345, 2'b00}, 20); pulseLe();
    sendBits(20'h0004D, 7); pulseLe();
    chkAll("R7 partial");
  endtask

  task automatic t_lock();
    sendBits({2'b00, 13'd100, 3'b000, 2'b11}, 20); pulseLe();
    lockRaw = 1'b1; waitClk(2);
    chk("R8", "lockOut ld000", 20'(lockOut), 20'd0);
    sendBits({2'b00, 13'd100, 3'b100, 2'b11}, 20); pulseLe();
    lockRaw = 1'b0; waitClk(2);
    chk("R8", "lockOut raw0", 20'(lockOut), 20'd0);
    lockRaw = 1'b1; waitClk(2);
    chk("R8", "lockOut raw1", 20'(lockOut), 20'd1);
    lockRaw = 1'b0;
    sendBits({1'b1, 1'b0, 16'd0, 2'b01}, 20); pulseLe();
    chk("R8", "lockOut standby", 20'(lockOut), 20'd1);
  endtask

  task automatic t_standby();
    sendBits({18'd4032, 2'b00}, 20); pulseLe();
    sendBits({2'b00, 13'd777, 3'b100, 2'b11}, 20); pulseLe();
    sendBits({1'b1, 1'b1, 16'd0, 2'b01}, 20); pulseLe();
    chkAll("R9 in standby");
    sendBits({1'b0, 1'b0, 16'd0, 2'b01}, 20); pulseLe();
    chkAll("R9 after standby");
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);
    t_reset();
    t_nload();
    t_opt();
    t_ref();
    t_noLe();
    t_partial();
    t_lock();
    t_standby();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule